// File: doc/BRIEF.md
# Hashed Multi-Size Translation Cache

This block caches virtual-to-physical translations of six page sizes in one direct-mapped array. Each slot is chosen by a multiplicative hash of the page-aligned virtual address. A translation of any size can therefore sit in any slot. A fill writes one translation into its hashed slot and replaces whatever was there. Per-size occupancy counters track which sizes are present, so a lookup can skip sizes the array cannot hold.

A lookup is accepted through a valid/ready handshake. The block then probes the array once per size, one size per clock, starting at the largest size with a nonzero count and stepping down to the smallest (4 KiB). It stops at the first probe that hits, or after it has probed the smallest size. The result comes back as a single-cycle response pulse. The response has no back-pressure: a consumer must take it in the cycle `rsp_valid` is high. The lookup side applies back-pressure with `lk_ready`, which is low while a walk is in progress and in any cycle where a fill or flush is presented. Fills and flushes have no handshake and are always taken.

When the translation base input is zero, address translation is off and the input address comes back unchanged. Flush invalidates every slot.

Top module: `hashed_tlb`

## Requirements
- R1: A fill of size level L (0..5) with virtual page V writes slot `((V * 106039) mod 2^64 >> 16) mod ENTRIES` and overwrites its previous content. A lookup probe at level i uses the same formula on the lookup address with its low 12+9*i bits cleared.
- R2: A slot is valid only when at least one of its permission bits (bit0 read, bit1 write, bit2 execute) is set. A flush makes every slot invalid, so later lookups miss, and it also clears every size count.
- R3: On a fill, the count of the overwritten entry's size is decremented if that entry was valid. The count of the new size is incremented if the new entry is valid. A walk starts at the highest level whose count is nonzero, or at level 0 when all counts are zero.
- R4: A walk probes one level per clock, in descending order. `rsp_valid` rises k+1 cycles after the accepting edge when k levels are probed. k is the number of levels from the start level down to the hitting level, or start+1 on a miss.
- R5: A probe at level i hits only when the slot is valid, its stored level equals i, the stored page equals the lookup address above bit 12+9*i, and the stored permissions share a bit with `lk_perm`.
- R6: A user-mode lookup (`lk_priv` = 0) to a non-user entry, or a lookup with `lk_priv` ≠ 0 to a user entry while `lk_sum` = 0, does not hit at that level, and the walk continues with smaller levels.
- R7: With `lk_satp` = 0, the response comes one cycle after acceptance with `rsp_hit` = 1, `rsp_paddr` = `lk_vaddr` and `rsp_pte_addr` = 0.
- R8: On a hit at level i, `rsp_paddr` is the stored physical page plus the low 12+9*i bits of the lookup address, and `rsp_pte_addr` is the stored leaf-entry address.
- R9: On a miss, `rsp_hit` = 0 and both `rsp_paddr` and `rsp_pte_addr` are zero.
- R10: A fill or flush presented in the same cycle as a lookup request wins: `lk_ready` is low in that cycle, and the lookup is taken later and sees the filled entry.
- R11: `rsp_valid` is high for exactly one cycle per accepted lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all slots and clear counts |
| fill_valid | input | 1 | Write a translation this cycle |
| fill_vpage | input | 64 | Size-aligned virtual page |
| fill_ppage | input | 64 | Size-aligned physical page |
| fill_pte_addr | input | 64 | Address of the leaf entry |
| fill_level | input | 3 | Size level 0..5 (page = 2^(12+9*level)) |
| fill_perm | input | 3 | Permissions: bit0 R, bit1 W, bit2 X |
| fill_user | input | 1 | Entry belongs to user mode |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_vaddr | input | 64 | Virtual address to translate |
| lk_perm | input | 3 | Required permission mask |
| lk_priv | input | 2 | Privilege; 0 is user |
| lk_sum | input | 1 | Supervisor may use user entries |
| lk_satp | input | 64 | Translation base; zero disables translation |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Translation found |
| rsp_paddr | output | 64 | Physical address |
| rsp_pte_addr | output | 64 | Leaf entry address of the hit |

## Verification
The bench aims at the cases where sizes interact. In one case a large user entry is refused and the walk must fall through to a smaller supervisor entry; a design that stopped early would report a miss. In another, an entry is overwritten by one of a smaller size; if the count were not decremented, the walk would start too high and answer one or more cycles late. A flush followed by a lookup must miss after a single probe. A level-5 entry checks the widest offset mask, and a wrong shift gives a wrong physical address. Same-cycle fill and lookup checks that the lookup waits and then sees the new entry rather than stale contents.

// File: rtl/hashed_tlb_pkg.sv
package hashed_tlb_pkg;
  localparam int ADDR_W = 64;
  localparam int LEVELS = 6;
  localparam int LVL_W  = 3;
  localparam logic [ADDR_W-1:0] HASH_MUL = 64'd106039;

  typedef struct packed {
    logic [ADDR_W-1:0] vpage;
    logic [ADDR_W-1:0] ppage;
    logic [ADDR_W-1:0] pte_addr;
    logic [LVL_W-1:0]  level;
    logic [2:0]        perm;
    logic              user;
  } xl_entry_t;

  // Mask that keeps address bits at and above 12+9*lvl.
  function automatic logic [ADDR_W-1:0] page_mask(input logic [LVL_W-1:0] lvl);
    int unsigned sh;
    sh = 12 + 9 * int'(lvl);
    page_mask = ~((64'd1 << sh) - 64'd1);
  endfunction

  // Product shifted right by 16; the caller keeps the low index bits.
  function automatic logic [ADDR_W-1:0] hash_full(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] prod;
    prod = a * HASH_MUL;
    hash_full = prod >> 16;
  endfunction
endpackage

// File: rtl/hashed_tlb_store.sv
module hashed_tlb_store
  import hashed_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  xl_entry_t        wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output xl_entry_t        rd_entry,
  output logic [LEVELS-1:0] occ_nz,
  output logic [LVL_W-1:0] max_lvl
);
  xl_entry_t slots [ENTRIES];
  logic [CNT_W-1:0] cnt [LEVELS];
  logic [ADDR_W-1:0] wr_hash;
  logic [IDX_W-1:0]  wr_idx;
  xl_entry_t         old_entry;
  logic              old_valid, new_valid;

  assign wr_hash   = hash_full(wr_entry.vpage);
  assign wr_idx    = wr_hash[IDX_W-1:0];
  assign old_entry = slots[wr_idx];
  assign old_valid = |old_entry.perm;
  assign new_valid = |wr_entry.perm;
  assign rd_entry  = slots[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int k = 0; k < ENTRIES; k++) slots[k] <= '0;
    end else if (wr_en) begin
      slots[wr_idx] <= wr_entry;
    end
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_cnt
    logic dec, inc;
    assign dec = wr_en && old_valid && (old_entry.level == LVL_W'(l));
    assign inc = wr_en && new_valid && (wr_entry.level == LVL_W'(l));
    always_ff @(posedge clk) begin
      if (!rst_n || flush) cnt[l] <= '0;
      else if (inc && !dec) cnt[l] <= cnt[l] + CNT_W'(1);
      else if (dec && !inc) cnt[l] <= cnt[l] - CNT_W'(1);
    end
    assign occ_nz[l] = |cnt[l];
  end

  always_comb begin
    max_lvl = '0;
    for (int l = 0; l < LEVELS; l++)
      if (occ_nz[l]) max_lvl = LVL_W'(l);
  end
endmodule

// File: rtl/hashed_tlb_probe.sv
module hashed_tlb_probe
  import hashed_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [2:0]        req_perm,
  input  logic [1:0]        priv,
  input  logic              sum,
  output logic [IDX_W-1:0]  idx,
  input  xl_entry_t         entry,
  output logic              hit,
  output logic [ADDR_W-1:0] paddr
);
  logic [ADDR_W-1:0] msk, h;
  logic valid, size_ok, tag_ok, perm_ok, priv_ok;

  assign msk     = page_mask(lvl);
  assign h       = hash_full(vaddr & msk);
  assign idx     = h[IDX_W-1:0];
  assign valid   = |entry.perm;
  assign size_ok = entry.level == lvl;
  assign tag_ok  = ((vaddr ^ entry.vpage) & msk) == '0;
  assign perm_ok = |(entry.perm & req_perm);
  assign priv_ok = !((priv == 2'd0 && !entry.user) ||
                     (priv != 2'd0 && entry.user && !sum));
  assign hit     = valid && size_ok && tag_ok && perm_ok && priv_ok;
  assign paddr   = entry.ppage + (vaddr & ~msk);
endmodule

// File: rtl/hashed_tlb.sv
module hashed_tlb
  import hashed_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        fill_valid,
  input  logic [63:0] fill_vpage,
  input  logic [63:0] fill_ppage,
  input  logic [63:0] fill_pte_addr,
  input  logic [2:0]  fill_level,
  input  logic [2:0]  fill_perm,
  input  logic        fill_user,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [63:0] lk_vaddr,
  input  logic [2:0]  lk_perm,
  input  logic [1:0]  lk_priv,
  input  logic        lk_sum,
  input  logic [63:0] lk_satp,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic [63:0] rsp_paddr,
  output logic [63:0] rsp_pte_addr
);
  typedef enum logic {ST_IDLE, ST_WALK} st_t;
  st_t st;

  logic [ADDR_W-1:0] q_va;
  logic [2:0]        q_perm;
  logic [1:0]        q_priv;
  logic              q_sum;
  logic [LVL_W-1:0]  cur_lvl;
  logic              walking;

  xl_entry_t         wr_entry, rd_entry;
  logic              wr_en;
  logic [IDX_W-1:0]  rd_idx;
  logic [LEVELS-1:0] occ_nz;
  logic [LVL_W-1:0]  max_lvl;
  logic              p_hit;
  logic [ADDR_W-1:0] p_paddr;
  logic              accept;

  assign wr_en    = fill_valid && !flush && (fill_level < LVL_W'(LEVELS));
  assign wr_entry = '{vpage: fill_vpage, ppage: fill_ppage, pte_addr: fill_pte_addr,
                      level: fill_level, perm: fill_perm, user: fill_user};
  assign walking  = st == ST_WALK;
  assign lk_ready = !walking && !fill_valid && !flush;
  assign accept   = lk_valid && lk_ready;

  hashed_tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_en), .wr_entry(wr_entry),
    .rd_idx(rd_idx), .rd_entry(rd_entry),
    .occ_nz(occ_nz), .max_lvl(max_lvl)
  );

  hashed_tlb_probe #(.ENTRIES(ENTRIES)) u_probe (
    .vaddr(q_va), .lvl(cur_lvl), .req_perm(q_perm), .priv(q_priv), .sum(q_sum),
    .idx(rd_idx), .entry(rd_entry), .hit(p_hit), .paddr(p_paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      q_va         <= '0;
      q_perm       <= '0;
      q_priv       <= '0;
      q_sum        <= 1'b0;
      cur_lvl      <= '0;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_paddr    <= '0;
      rsp_pte_addr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          q_va   <= lk_vaddr;
          q_perm <= lk_perm;
          q_priv <= lk_priv;
          q_sum  <= lk_sum;
          if (lk_satp == '0) begin
            rsp_valid    <= 1'b1;
            rsp_hit      <= 1'b1;
            rsp_paddr    <= lk_vaddr;
            rsp_pte_addr <= '0;
          end else begin
            st      <= ST_WALK;
            cur_lvl <= max_lvl;
          end
        end
        ST_WALK: begin
          if (p_hit) begin
            rsp_valid    <= 1'b1;
            rsp_hit      <= 1'b1;
            rsp_paddr    <= p_paddr;
            rsp_pte_addr <= rd_entry.pte_addr;
            st           <= ST_IDLE;
          end else if (cur_lvl == '0) begin
            rsp_valid    <= 1'b1;
            rsp_hit      <= 1'b0;
            rsp_paddr    <= '0;
            rsp_pte_addr <= '0;
            st           <= ST_IDLE;
          end else begin
            cur_lvl <= cur_lvl - LVL_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hashed_tlb_chk.sv
module hashed_tlb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        fill_valid,
  input logic        lk_valid,
  input logic        lk_ready,
  input logic [63:0] lk_vaddr,
  input logic [63:0] lk_satp,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [63:0] rsp_paddr,
  input logic [63:0] rsp_pte_addr,
  input logic [5:0]  occ_nz,
  input logic        walking,
  input logic [2:0]  cur_lvl
);
  AST_FILL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ready |-> (!fill_valid && !flush)); // R10

  AST_BARE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && lk_satp == 64'd0) |=>
      (rsp_valid && rsp_hit && rsp_paddr == $past(lk_vaddr))); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ_nz == 6'd0)); // R2

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == 64'd0 && rsp_pte_addr == 64'd0)); // R9

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && $past(walking)) |-> (cur_lvl == $past(cur_lvl) - 3'd1)); // R4

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11
endmodule

bind hashed_tlb hashed_tlb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fill_valid(fill_valid),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr), .lk_satp(lk_satp),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
  .rsp_pte_addr(rsp_pte_addr), .occ_nz(occ_nz), .walking(walking), .cur_lvl(cur_lvl)
);

// File: tb/sim_hashed_tlb.sv
module sim_hashed_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, fill_valid = 1'b0;
  logic [63:0] fill_vpage = '0, fill_ppage = '0, fill_pte_addr = '0;
  logic [2:0] fill_level = '0, fill_perm = '0;
  logic fill_user = 1'b0, lk_valid = 1'b0, lk_ready, lk_sum = 1'b0;
  logic [63:0] lk_vaddr = '0, lk_satp = '0;
  logic [2:0] lk_perm = '0;
  logic [1:0] lk_priv = '0;
  logic rsp_valid, rsp_hit;
  logic [63:0] rsp_paddr, rsp_pte_addr;

  int checks = 0, errors = 0;

  hashed_tlb u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  logic [63:0] m_vp [N];
  logic [63:0] m_pp [N];
  logic [63:0] m_pa [N];
  logic [2:0]  m_lv [N];
  logic [2:0]  m_pm [N];
  logic        m_us [N];
  int          m_cnt [6];
  logic [63:0] recent [16];

  function automatic logic [63:0] msk_of(input int l);
    return ~((64'd1 << (12 + 9*l)) - 64'd1);
  endfunction
  function automatic int idx_of(input logic [63:0] a);
    logic [63:0] p;
    p = a * 64'd106039;
    return int'(p[21:16]);
  endfunction

  task automatic model_clear();
    for (int k = 0; k < N; k++) begin
      m_vp[k] = '0; m_pp[k] = '0; m_pa[k] = '0; m_lv[k] = '0; m_pm[k] = '0; m_us[k] = 1'b0;
    end
    for (int l = 0; l < 6; l++) m_cnt[l] = 0;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_fill(input logic [63:0] vp, input logic [63:0] pp, input logic [63:0] pa,
                         input int lv, input logic [2:0] pm, input logic us);
    int i;
    @(negedge clk);
    fill_valid = 1'b1; fill_vpage = vp; fill_ppage = pp; fill_pte_addr = pa;
    fill_level = 3'(lv); fill_perm = pm; fill_user = us;
    @(negedge clk);
    fill_valid = 1'b0;
    i = idx_of(vp);
    if (m_pm[i] != 3'd0) m_cnt[m_lv[i]]--;
    if (pm != 3'd0) m_cnt[lv]++;
    m_vp[i] = vp; m_pp[i] = pp; m_pa[i] = pa; m_lv[i] = 3'(lv); m_pm[i] = pm; m_us[i] = us;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_clear();
  endtask

  task automatic ref_lookup(input logic [63:0] va, input logic [2:0] pm, input logic [1:0] pv,
                            input logic sm, input logic [63:0] st,
                            output logic hit, output logic [63:0] pa, output logic [63:0] pte,
                            output int lat);
    int top, i;
    logic [63:0] m;
    hit = 1'b0; pa = '0; pte = '0;
    if (st == 64'd0) begin hit = 1'b1; pa = va; lat = 1; return; end
    top = 0;
    for (int l = 0; l < 6; l++) if (m_cnt[l] > 0) top = l;
    lat = 1;
    for (int l = top; l >= 0; l--) begin
      lat++;
      m = msk_of(l);
      i = idx_of(va & m);
      if (m_pm[i] != 3'd0 && int'(m_lv[i]) == l && ((va ^ m_vp[i]) & m) == 64'd0 &&
          (m_pm[i] & pm) != 3'd0 &&
          !((pv == 2'd0 && !m_us[i]) || (pv != 2'd0 && m_us[i] && !sm))) begin
        hit = 1'b1; pa = m_pp[i] + (va & ~m); pte = m_pa[i];
        return;
      end
    end
  endtask

  // Starts at a negedge with lk_ready expected high.
  task automatic do_lookup(input string tag, input logic [63:0] va, input logic [2:0] pm,
                           input logic [1:0] pv, input logic sm, input logic [63:0] st);
    logic eh; logic [63:0] ep, et; int el, n;
    ref_lookup(va, pm, pv, sm, st, eh, ep, et, el);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_perm = pm; lk_priv = pv; lk_sum = sm; lk_satp = st;
    check({tag, " R10 ready idle"}, 64'(lk_ready), 64'd1);
    n = 0;
    @(negedge clk);
    lk_valid = 1'b0;
    n = 1;
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    check({tag, " R4 latency"}, 64'(n), 64'(el));
    check({tag, " R5 R6 hit"}, 64'(rsp_hit), 64'(eh));
    check({tag, " R8 R9 paddr"}, rsp_paddr, ep);
    check({tag, " R8 pte"}, rsp_pte_addr, et);
    @(negedge clk);
    check({tag, " R11 pulse"}, 64'(rsp_valid), 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [63:0] SATP = 64'h8000_0000_0008_0000;

  initial begin : main
    void'($urandom(32'd5150));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R10 reset ready", 64'(lk_ready), 64'd1);

    // R7 bare pass-through
    do_lookup("R7 bare", 64'hDEAD_BEEF_1234_5678, 3'd1, 2'd1, 1'b0, 64'd0);
    // empty: single probe miss (R3, R9)
    do_lookup("R3 empty miss", 64'h0000_0040_0000_1000, 3'd1, 2'd1, 1'b0, SATP);

    // R1 R8 basic 4K hit with offset
    do_fill(64'h0000_0012_3456_7000, 64'h0000_0000_8000_3000, 64'h8000_1000, 0, 3'b011, 1'b0);
    do_lookup("R1 4k hit", 64'h0000_0012_3456_7ABC, 3'b001, 2'd1, 1'b0, SATP);
    // R5 permission mismatch
    do_lookup("R5 perm miss", 64'h0000_0012_3456_7ABC, 3'b100, 2'd1, 1'b0, SATP);
    // R6 user mode on supervisor entry
    do_lookup("R6 user deny", 64'h0000_0012_3456_7ABC, 3'b001, 2'd0, 1'b1, SATP);

    // R6 fall-through: large user entry refused, small supervisor entry hits
    do_fill(64'h0000_0055_4000_0000, 64'h0000_0001_0000_0000, 64'h8000_2000, 2, 3'b111, 1'b1);
    do_fill(64'h0000_0055_4000_5000, 64'h0000_0000_9000_0000, 64'h8000_3000, 0, 3'b001, 1'b0);
    do_lookup("R6 fallthrough", 64'h0000_0055_4000_5010, 3'b001, 2'd1, 1'b0, SATP);
    do_lookup("R6 sum allows", 64'h0000_0055_4000_5010, 3'b001, 2'd1, 1'b1, SATP);

    // R8 level-5 entry
    do_fill(64'h0200_0000_0000_0000, 64'h0400_0000_0000_0000, 64'h8000_4000, 5, 3'b100, 1'b0);
    do_lookup("R8 lvl5", 64'h0201_2345_6789_ABCD, 3'b100, 2'd3, 1'b0, SATP);

    // R3 overwrite smaller size drops max level
    do_fill(64'h0200_0000_0000_0000, 64'h0000_0000_7000_0000, 64'h8000_5000, 0, 3'b001, 1'b0);
    do_lookup("R3 overwrite", 64'h0200_0000_0000_0123, 3'b001, 2'd1, 1'b0, SATP);

    // R2 zero-permission fill is invalid
    do_fill(64'h0000_0077_0000_1000, 64'h1000, 64'h8000_6000, 0, 3'b000, 1'b0);
    do_lookup("R2 zero perm", 64'h0000_0077_0000_1000, 3'b111, 2'd1, 1'b1, SATP);

    // R10 same-cycle fill and lookup
    @(negedge clk);
    fill_valid = 1'b1; fill_vpage = 64'h0000_0099_0000_2000; fill_ppage = 64'h0000_0000_A000_0000;
    fill_pte_addr = 64'h8000_7000; fill_level = 3'd0; fill_perm = 3'b010; fill_user = 1'b1;
    lk_valid = 1'b1; lk_vaddr = 64'h0000_0099_0000_2004;
    #1 check("R10 fill blocks ready", 64'(lk_ready), 64'd0);
    begin
      int i;
      i = idx_of(64'h0000_0099_0000_2000);
      if (m_pm[i] != 3'd0) m_cnt[m_lv[i]]--;
      m_cnt[0]++;
      m_vp[i] = 64'h0000_0099_0000_2000; m_pp[i] = 64'h0000_0000_A000_0000;
      m_pa[i] = 64'h8000_7000; m_lv[i] = 3'd0; m_pm[i] = 3'b010; m_us[i] = 1'b1;
    end
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    do_lookup("R10 after fill", 64'h0000_0099_0000_2004, 3'b010, 2'd0, 1'b0, SATP);

    // R2 flush
    do_flush();
    do_lookup("R2 flush miss", 64'h0000_0099_0000_2004, 3'b010, 2'd0, 1'b0, SATP);

    for (int k = 0; k < 16; k++) recent[k] = {$urandom, $urandom} & msk_of(0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 35) begin
        int lv, slot;
        logic [63:0] vp;
        lv = (($urandom % 8) == 0) ? 5 : int'($urandom % 3);
        slot = int'($urandom % 16);
        vp = recent[slot] & msk_of(lv);
        recent[slot] = vp;
        do_fill(vp, {$urandom, $urandom} & msk_of(lv), {$urandom, $urandom},
                lv, 3'(1 + $urandom % 7), 1'($urandom));
      end else if (r < 37) begin
        do_flush();
      end else begin
        logic [63:0] va, st;
        va = (($urandom % 5) == 0) ? {$urandom, $urandom}
             : (recent[$urandom % 16] | 64'($urandom % 4096));
        st = (($urandom % 10) == 0) ? 64'd0 : SATP;
        do_lookup("rand R5", va, 3'(1 + $urandom % 7), 2'($urandom), 1'($urandom), st);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule